// File: doc/BRIEF.md
# Keypad Tone Selection Logic

This block sits between a 4x4 telephone-style keypad, or an electronic driver that imitates one, and a dual-frequency tone synthesiser. It reads four active-low row lines and four active-low column lines and decides whether a low-group (row) tone and a high-group (column) tone should sound. For each tone it also gives a 2-bit index that picks the frequency.

Every input first crosses into the clock domain through a two-flop synchroniser. The key lines then pass through a settle filter. A new key pattern reaches the decoder only after it has held unchanged for `HOLD_TICKS` consecutive clocks. The decoder applies fixed rules for abnormal line patterns. It honours a global tone-off control and a lone-tone block control. It also drives an active-low key-present flag that neither control affects. All outputs are registered.

Top module: `keypad_tone_select`

## Requirements
- R1: During and right after reset, `row_en` and `col_en` are 0, both indices are 0 and `key_down_n` is 1.
- R2: With exactly one row line k and exactly one column line j low, both enables are 1, `row_idx` = k and `col_idx` = j. Line number i is bit i of its bus.
- R3: With `solo_block` = 0, exactly one column line j low and no row line low, only `col_en` is 1 and `col_idx` = j.
- R4: With two or more column lines low, `col_en` is 0.
- R5: With one or more row lines low and no column line low, both enables are 0.
- R6: With `solo_block` = 0, exactly two column lines low and exactly one row line k low, only `row_en` is 1 and `row_idx` = k. With three or four columns low, both enables are 0.
- R7: With `solo_block` = 1, any pattern that would give a lone row tone or a lone column tone gives both enables 0. A one-row, one-column pattern still gives both tones.
- R8: With `tone_off` = 1, both enables are 0 for every key pattern.
- R9: `key_down_n` is 0 exactly when at least one settled row or column line is low, whatever `tone_off` and `solo_block` are.
- R10: Two or more row lines low count as an invalid row, so `row_en` is 0. If exactly one column is low and `solo_block` = 0, that column's tone alone still sounds.
- R11: A key-line change that lasts fewer than `HOLD_TICKS` clocks never changes any output. A change that is held steady does reach the outputs.
- R12: Whenever an enable is 0, its index output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n | input | 4 | Row lines, active low |
| col_n | input | 4 | Column lines, active low |
| tone_off | input | 1 | High: no tone for any key pattern |
| solo_block | input | 1 | High: lone row or lone column tones are suppressed |
| row_en | output | 1 | Row tone enable |
| col_en | output | 1 | Column tone enable |
| row_idx | output | 2 | Selected row frequency index |
| col_idx | output | 2 | Selected column frequency index |
| key_down_n | output | 1 | Low while any settled key line is low |

## Verification
The hardest case to reach from the ports is a short burst on the key lines that must be rejected while a valid tone is already sounding. The filter has to restart its count, and the outputs must never move. The bench first settles a dual-tone pattern. It then drives a different pattern for fewer clocks than the hold window and returns to the original. It checks the outputs on every clock through the burst and for a full settle time after it. Lone-row tones also need an unusual stimulus: two columns and one row held low together. The bench drives this pattern under both settings of the lone-tone control.

// File: rtl/kts_pkg.sv
package kts_pkg;
  localparam int KP_LINES = 4;
  localparam int IDX_W    = 2;

  typedef struct packed {
    logic             row_en;
    logic             col_en;
    logic [IDX_W-1:0] row_idx;
    logic [IDX_W-1:0] col_idx;
  } tone_sel_t;

  // Index of the lowest-numbered active (low) line.
  function automatic logic [IDX_W-1:0] first_low(input logic [KP_LINES-1:0] lines_n);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = KP_LINES - 1; i >= 0; i--) begin
      if (!lines_n[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  function automatic int unsigned low_count(input logic [KP_LINES-1:0] lines_n);
    return $countones(~lines_n);
  endfunction

  function automatic tone_sel_t decode_keys(input logic [KP_LINES-1:0] row_n,
                                            input logic [KP_LINES-1:0] col_n,
                                            input logic off,
                                            input logic solo);
    tone_sel_t   s;
    int unsigned nr;
    int unsigned nc;
    nr = low_count(row_n);
    nc = low_count(col_n);
    s  = '0;
    if (!off) begin
      if (nc == 1 && nr == 1) begin
        s.row_en = 1'b1;
        s.col_en = 1'b1;
      end else if (nc == 1 && !solo) begin
        s.col_en = 1'b1;
      end else if (nc == 2 && nr == 1 && !solo) begin
        s.row_en = 1'b1;
      end
    end
    if (s.row_en) s.row_idx = first_low(row_n);
    if (s.col_en) s.col_idx = first_low(col_n);
    return s;
  endfunction
endpackage

// File: rtl/kts_sync.sv
module kts_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= RST_VAL;
      else        stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/kts_settle.sv
module kts_settle #(
  parameter int           W          = 8,
  parameter int           HOLD_TICKS = 1000,
  parameter logic [W-1:0] RST_VAL    = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] stable,
  output logic         done
);
  localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [W-1:0]  cand;
  logic [CW-1:0] cnt;

  assign done = (raw == cand) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand   <= RST_VAL;
      cnt    <= '0;
      stable <= RST_VAL;
    end else if (raw != cand) begin
      cand <= raw;
      cnt  <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end else begin
      stable <= cand;
    end
  end
endmodule

// File: rtl/kts_decode.sv
module kts_decode
  import kts_pkg::*;
(
  input  logic [KP_LINES-1:0] row_n,
  input  logic [KP_LINES-1:0] col_n,
  input  logic                off,
  input  logic                solo,
  output tone_sel_t           sel,
  output logic                any_low
);
  assign sel     = decode_keys(row_n, col_n, off, solo);
  assign any_low = (low_count(row_n) + low_count(col_n)) != 0;
endmodule

// File: rtl/keypad_tone_select.sv
module keypad_tone_select
  import kts_pkg::*;
#(
  parameter int HOLD_TICKS  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] row_n,
  input  logic [3:0] col_n,
  input  logic       tone_off,
  input  logic       solo_block,
  output logic       row_en,
  output logic       col_en,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx,
  output logic       key_down_n
);
  localparam int KW = 2 * KP_LINES;
  localparam int SW = KW + 2;

  logic [SW-1:0] sync_q;
  logic [KW-1:0] keys_s;
  logic          off_s;
  logic          solo_s;
  logic [KW-1:0] stable_n;
  logic          settle_done;
  tone_sel_t     sel;
  logic          any_low;

  kts_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({2'b00, {KW{1'b1}}})) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({solo_block, tone_off, col_n, row_n}),
    .q(sync_q)
  );

  assign keys_s = sync_q[KW-1:0];
  assign off_s  = sync_q[KW];
  assign solo_s = sync_q[KW+1];

  kts_settle #(.W(KW), .HOLD_TICKS(HOLD_TICKS), .RST_VAL({KW{1'b1}})) u_settle (
    .clk(clk), .rst_n(rst_n),
    .raw(keys_s), .stable(stable_n), .done(settle_done)
  );

  kts_decode u_decode (
    .row_n(stable_n[KP_LINES-1:0]),
    .col_n(stable_n[KW-1:KP_LINES]),
    .off(off_s), .solo(solo_s),
    .sel(sel), .any_low(any_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_en     <= 1'b0;
      col_en     <= 1'b0;
      row_idx    <= '0;
      col_idx    <= '0;
      key_down_n <= 1'b1;
    end else begin
      row_en     <= sel.row_en;
      col_en     <= sel.col_en;
      row_idx    <= sel.row_idx;
      col_idx    <= sel.col_idx;
      key_down_n <= ~any_low;
    end
  end
endmodule

// File: rtl/keypad_tone_select_chk.sv
module keypad_tone_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       off_s,
  input logic       solo_s,
  input logic [7:0] stable_n,
  input logic       settle_done,
  input logic       row_en,
  input logic       col_en,
  input logic [1:0] row_idx,
  input logic [1:0] col_idx,
  input logic       key_down_n
);
  assert_tone_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    off_s |=> (!row_en && !col_en));

  assert_no_lone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    solo_s |=> (row_en == col_en));

  assert_row_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    row_en |-> ($countones(~$past(stable_n[3:0])) == 1));

  assert_col_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_en |-> ($countones(~$past(stable_n[7:4])) == 1));

  assert_key_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_down_n == ($past(stable_n) == 8'hFF));

  assert_settle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stable_n) |-> $past(settle_done));

  assert_idx_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((!row_en -> row_idx == 2'd0) && (!col_en -> col_idx == 2'd0)));
endmodule

bind keypad_tone_select keypad_tone_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .off_s(off_s), .solo_s(solo_s),
  .stable_n(stable_n), .settle_done(settle_done),
  .row_en(row_en), .col_en(col_en), .row_idx(row_idx), .col_idx(col_idx),
  .key_down_n(key_down_n)
);

// File: tb/keypad_tone_select_bench.sv
module keypad_tone_select_bench;
  localparam int HOLD = 8;
  localparam int SETTLE = HOLD + 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row_n = 4'hF;
  logic [3:0] col_n = 4'hF;
  logic       tone_off = 1'b0;
  logic       solo_block = 1'b0;
  logic       row_en, col_en, key_down_n;
  logic [1:0] row_idx, col_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keypad_tone_select #(.HOLD_TICKS(HOLD)) u_keypad_tone_select (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .tone_off(tone_off), .solo_block(solo_block),
    .row_en(row_en), .col_en(col_en), .row_idx(row_idx), .col_idx(col_idx),
    .key_down_n(key_down_n)
  );

  function automatic int lows(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i] == 1'b0) n++;
    return n;
  endfunction

  function automatic logic [1:0] pos(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i] == 1'b0) return 2'(i);
    return 2'd0;
  endfunction

  // Expected {row_en, col_en, row_idx, col_idx, key_down_n}
  function automatic logic [6:0] model(input logic [3:0] r, input logic [3:0] c,
                                       input logic off, input logic solo);
    logic re = 1'b0, ce = 1'b0;
    int nr = lows(r), nc = lows(c);
    case (nc)
      1: begin
        if (nr == 1) begin re = 1'b1; ce = 1'b1; end
        else ce = !solo;
      end
      2: re = (nr == 1) && !solo;
      default: ;
    endcase
    if (off) begin re = 1'b0; ce = 1'b0; end
    return {re, ce, re ? pos(r) : 2'd0, ce ? pos(c) : 2'd0, (nr + nc) == 0};
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] got = {row_en, col_en, row_idx, col_idx, key_down_n};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [3:0] r, input logic [3:0] c,
                       input logic off, input logic solo);
    @(negedge clk);
    row_n = r; col_n = c; tone_off = off; solo_block = solo;
    repeat (SETTLE) @(negedge clk);
    check(req, model(r, c, off, solo));
  endtask

  task automatic t_reset;
    check("R1", 7'b0000001);
  endtask

  task automatic t_dual;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++)
        apply("R2", ~(4'b1 << k), ~(4'b1 << ((j + k) % 4)), 1'b0, 1'b0);
  endtask

  task automatic t_lone_col;
    apply("R3", 4'hF, 4'b1011, 1'b0, 1'b0);
    apply("R3", 4'hF, 4'b0111, 1'b0, 1'b0);
  endtask

  task automatic t_multi_col;
    apply("R4", 4'hF, 4'b0011, 1'b0, 1'b0);
    apply("R4", 4'b1100, 4'b0101, 1'b0, 1'b0);
  endtask

  task automatic t_rows_only;
    apply("R5", 4'b1101, 4'hF, 1'b0, 1'b0);
    apply("R5", 4'b0000, 4'hF, 1'b0, 1'b0);
  endtask

  task automatic t_lone_row;
    apply("R6", 4'b1011, 4'b1001, 1'b0, 1'b0);
    apply("R6", 4'b0111, 4'b0110, 1'b0, 1'b0);
    apply("R6", 4'b1110, 4'b1000, 1'b0, 1'b0);
  endtask

  task automatic t_solo;
    apply("R7", 4'b1011, 4'b1001, 1'b0, 1'b1);
    apply("R7", 4'hF, 4'b1101, 1'b0, 1'b1);
    apply("R7", 4'b1101, 4'b0111, 1'b0, 1'b1);
  endtask

  task automatic t_off;
    apply("R8", 4'b1110, 4'b1110, 1'b1, 1'b0);
    apply("R8", 4'hF, 4'b1101, 1'b1, 1'b0);
    apply("R8", 4'b0111, 4'b0101, 1'b1, 1'b0);
  endtask

  task automatic t_key_flag;
    apply("R9", 4'b1110, 4'hF, 1'b1, 1'b1);
    apply("R9", 4'hF, 4'b0011, 1'b1, 1'b0);
    apply("R9", 4'hF, 4'hF, 1'b0, 1'b1);
  endtask

  task automatic t_bad_row;
    apply("R10", 4'b0110, 4'b1011, 1'b0, 1'b0);
    apply("R10", 4'b1100, 4'b1110, 1'b0, 1'b1);
  endtask

  task automatic t_glitch;
    logic [6:0] keep;
    apply("R11", 4'b1101, 4'b1110, 1'b0, 1'b0);
    keep = model(4'b1101, 4'b1110, 1'b0, 1'b0);
    row_n = 4'b0111; col_n = 4'b0111;
    for (int i = 0; i < HOLD - 2; i++) begin
      @(negedge clk);
      check("R11", keep);
    end
    row_n = 4'b1101; col_n = 4'b1110;
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      check("R11", keep);
    end
    apply("R11", 4'b0111, 4'b0111, 1'b0, 1'b0);
  endtask

  task automatic t_idx_zero;
    apply("R12", 4'b0111, 4'b0011, 1'b0, 1'b0);
    apply("R12", 4'hF, 4'hF, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dual();
    t_lone_col();
    t_multi_col();
    t_rows_only();
    t_lone_row();
    t_solo();
    t_off();
    t_key_flag();
    t_bad_row();
    t_glitch();
    t_idx_zero();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule